// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Macrocells

This block is a small reconfigurable logic array. It has a programmable AND plane and a fixed OR grouping. A serial configuration chain decides which literals connect to each product term. Each product term can use the true rail, the complemented rail, or neither, for every literal. The literals are the primary inputs followed by one feedback signal per output. Each output ORs a fixed group of consecutive product terms.

Each OR result then passes through an output macrocell. The macrocell holds a rising-edge flip-flop and a configured choice between the combinational and registered value. It also has a configured output enable, which the block presents as a data/enable pair for an external tri-state pad. Because each flip-flop feeds back into the array as a literal, the block can implement state machines as well as multi-level logic.

Software or a boot sequencer loads the configuration by holding `prog_en` high and shifting in one bit per clock. All enables stay low while loading. A synchronous reset clears the flip-flops and leaves the configuration unchanged.

Top module: `sop_array`

## Requirements
- R1: The configuration bit at index t*2*NL + 2*l connects the true rail of literal l to product term t, and index t*2*NL + 2*l + 1 connects its complement. NL = N_IN + N_OUT. Literals 0..N_IN-1 are `in_pins`, and literal N_IN+o is the feedback of output o.
- R2: A product term with no connected rails evaluates to 1.
- R3: A product term connected to both rails of one literal evaluates to 0.
- R4: Output o ORs exactly the product terms o*PT_PER_OUT to o*PT_PER_OUT+PT_PER_OUT-1. Terms outside that group have no effect on it.
- R5: With its select bit at 0, `out_data[o]` is the OR value of the current inputs within the same cycle.
- R6: On each rising edge with `prog_en` and `rst` low, flip-flop o captures the OR value present before the edge. With the select bit at 1, `out_data[o]` shows that flip-flop.
- R7: The feedback literal of output o carries the flip-flop of output o.
- R8: `out_oe[o]` equals the enable bit for output o, at configuration index AND_BITS + 2*o + 1, whenever `prog_en` is low. It is 0 whenever `prog_en` is high. The select bit sits at index AND_BITS + 2*o, where AND_BITS = N_OUT*PT_PER_OUT*2*NL.
- R9: A clock edge with `rst` high clears every flip-flop to 0 and leaves the configuration unchanged.
- R10: Each edge with `prog_en` high shifts `cfg_din` in at the top index of the chain and moves every bit down by one. After CFG_W shifts, the first bit sent sits at index 0. The flip-flops hold their values during loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the macrocell flip-flops, active high |
| prog_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration bit |
| in_pins | input | N_IN | Primary inputs to the AND plane |
| out_data | output | N_OUT | Selected macrocell value per output |
| out_oe | output | N_OUT | Output enable per output for the pad buffer |

## Verification
The hardest situation to reach from the ports is a feedback state sequence, because registered outputs depend on history that only the array itself creates. The stimulus programs a toggling output and a second output that follows it through the feedback literal. It then interleaves reloads and a mid-run reset, so the hold during loading and the clear on reset both show up as breaks in the expected sequence. Sparse pseudo-random configurations, each swept over every input pattern twice, drive the flip-flops through many states. These results are compared against an arithmetic model of the array kept in the bench.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // Position of one rail of one literal for one product term.
    function automatic int rail_idx(input int term, input int lit, input int n_lit, input int compl_rail);
        return term * 2 * n_lit + 2 * lit + compl_rail;
    endfunction

    // Position of a macrocell control bit (0 = select, 1 = enable).
    function automatic int ctrl_idx(input int and_bits, input int out_idx, input int which);
        return and_bits + 2 * out_idx + which;
    endfunction

endpackage

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_LIT  = 6,
    parameter int N_TERM = 8
) (
    input  logic [N_LIT-1:0]          lits,
    input  logic [N_TERM*2*N_LIT-1:0] mask,
    output logic [N_TERM-1:0]         terms
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        always_comb begin
            terms[t] = 1'b1;
            for (int l = 0; l < N_LIT; l++) begin
                if (mask[sop_pkg::rail_idx(t, l, N_LIT, 0)] && !lits[l]) terms[t] = 1'b0;
                if (mask[sop_pkg::rail_idx(t, l, N_LIT, 1)] &&  lits[l]) terms[t] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
    parameter int N_OUT      = 2,
    parameter int PT_PER_OUT = 4
) (
    input  logic [N_OUT*PT_PER_OUT-1:0] terms,
    output logic [N_OUT-1:0]            or_val
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        assign or_val[o] = |terms[o*PT_PER_OUT +: PT_PER_OUT];
    end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell #(
    parameter int N_OUT = 2
) (
    input  logic [N_OUT-1:0] or_val,
    input  logic [N_OUT-1:0] ff_q,
    input  logic [N_OUT-1:0] sel_reg,
    input  logic [N_OUT-1:0] oe_cfg,
    input  logic             prog_en,
    output logic [N_OUT-1:0] out_data,
    output logic [N_OUT-1:0] out_oe
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_cell
        assign out_data[o] = sel_reg[o] ? ff_q[o] : or_val[o];
        assign out_oe[o]   = oe_cfg[o] & ~prog_en;
    end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int N_IN       = 4,
    parameter int PT_PER_OUT = 4,
    parameter int N_OUT      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_en,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  in_pins,
    output logic [N_OUT-1:0] out_data,
    output logic [N_OUT-1:0] out_oe
);
    localparam int N_LIT    = N_IN + N_OUT;
    localparam int N_TERM   = N_OUT * PT_PER_OUT;
    localparam int AND_BITS = N_TERM * 2 * N_LIT;
    localparam int CFG_W    = AND_BITS + 2 * N_OUT;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [N_OUT-1:0] ff;
    } state_t;

    state_t s_d, s_q;

    logic [N_OUT-1:0]  or_val;
    logic [N_TERM-1:0] terms;
    logic [N_LIT-1:0]  lits;
    logic [N_OUT-1:0]  sel_reg;
    logic [N_OUT-1:0]  oe_cfg;
    logic [N_OUT-1:0]  ff_q;
    logic              cfg_top;

    assign ff_q    = s_q.ff;
    assign cfg_top = s_q.cfg[CFG_W-1];

    // Feedback literals come from the flip-flops so the array stays acyclic.
    assign lits = {ff_q, in_pins};

    for (genvar o = 0; o < N_OUT; o++) begin : g_ctrl
        localparam int SEL_BIT = sop_pkg::ctrl_idx(AND_BITS, o, 0);
        localparam int OE_BIT  = sop_pkg::ctrl_idx(AND_BITS, o, 1);
        assign sel_reg[o] = s_q.cfg[SEL_BIT];
        assign oe_cfg[o]  = s_q.cfg[OE_BIT];
    end

    sop_and_plane #(.N_LIT(N_LIT), .N_TERM(N_TERM)) u_and (
        .lits  (lits),
        .mask  (s_q.cfg[AND_BITS-1:0]),
        .terms (terms)
    );

    sop_or_group #(.N_OUT(N_OUT), .PT_PER_OUT(PT_PER_OUT)) u_or (
        .terms  (terms),
        .or_val (or_val)
    );

    sop_macrocell #(.N_OUT(N_OUT)) u_mc (
        .or_val   (or_val),
        .ff_q     (ff_q),
        .sel_reg  (sel_reg),
        .oe_cfg   (oe_cfg),
        .prog_en  (prog_en),
        .out_data (out_data),
        .out_oe   (out_oe)
    );

    always_comb begin
        s_d = s_q;
        if (prog_en) begin
            s_d.cfg = {cfg_din, s_q.cfg[CFG_W-1:1]};
        end
        if (rst) begin
            s_d.ff = '0;
        end else if (!prog_en) begin
            s_d.ff = or_val;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_OUT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             prog_en,
    input logic             cfg_din,
    input logic             cfg_top,
    input logic [N_OUT-1:0] out_oe,
    input logic [N_OUT-1:0] ff_q,
    input logic [N_OUT-1:0] or_val
);
    p_oe_off_prog_r8: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> (out_oe == '0));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (ff_q == '0));

    p_hold_prog_r10: assert property (@(posedge clk) disable iff (rst)
        prog_en |=> $stable(ff_q));

    p_shift_in_r10: assert property (@(posedge clk) disable iff (rst)
        prog_en |=> (cfg_top == $past(cfg_din)));

    p_reg_capture_r6: assert property (@(posedge clk) disable iff (rst)
        !prog_en |=> (ff_q == $past(or_val)));
endmodule

bind sop_array sop_array_chk #(.N_OUT(N_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .prog_en (prog_en),
    .cfg_din (cfg_din),
    .cfg_top (cfg_top),
    .out_oe  (out_oe),
    .ff_q    (ff_q),
    .or_val  (or_val)
);

// File: tb/tb_sop_array.sv
`timescale 1ns/1ps
module tb_sop_array;
    localparam int NI = 4;
    localparam int PT = 4;
    localparam int NO = 2;
    localparam int NL = NI + NO;
    localparam int AB = NO * PT * 2 * NL;
    localparam int W  = AB + 2 * NO;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_en = 1'b0;
    logic cfg_din = 1'b0;
    logic [NI-1:0] in_pins = '0;
    logic [NO-1:0] out_data, out_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] cur_cfg;
    logic [NO-1:0] ffm;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    sop_array dut (
        .clk(clk), .rst(rst), .prog_en(prog_en), .cfg_din(cfg_din),
        .in_pins(in_pins), .out_data(out_data), .out_oe(out_oe)
    );

    task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic sum_of(input logic [W-1:0] c, input int o,
                                    input logic [NI-1:0] v, input logic [NO-1:0] f);
        logic s = 1'b0;
        for (int p = 0; p < PT; p++) begin
            int t = o * PT + p;
            logic term = 1'b1;
            for (int l = 0; l < NL; l++) begin
                logic lv = (l < NI) ? v[l] : f[l-NI];
                if (c[t*2*NL + 2*l] && !lv) term = 1'b0;
                if (c[t*2*NL + 2*l + 1] && lv) term = 1'b0;
            end
            s = s | term;
        end
        return s;
    endfunction

    function automatic logic [W-1:0] put(input logic [W-1:0] c, input int t, input int l, input int cr);
        logic [W-1:0] r = c;
        r[t*2*NL + 2*l + cr] = 1'b1;
        return r;
    endfunction

    function automatic logic [W-1:0] ctl(input logic [W-1:0] c, input int o, input logic sel, input logic oe);
        logic [W-1:0] r = c;
        r[AB + 2*o]     = sel;
        r[AB + 2*o + 1] = oe;
        return r;
    endfunction

    // Starts and ends right after a falling edge.
    task automatic load(input logic [W-1:0] c);
        prog_en = 1'b1;
        for (int i = 0; i < W; i++) begin
            cfg_din = c[i];
            if (i == W / 2) begin
                #1;
                check("R8 enables low while loading", out_oe, '0);
            end
            @(negedge clk);
        end
        prog_en = 1'b0;
        cur_cfg = c;
    endtask

    task automatic run_vec(input logic [NI-1:0] v, input string tag);
        logic [NO-1:0] exp_d, exp_oe, nx;
        in_pins = v;
        #1;
        for (int o = 0; o < NO; o++) begin
            exp_d[o]  = cur_cfg[AB + 2*o] ? ffm[o] : sum_of(cur_cfg, o, v, ffm);
            exp_oe[o] = cur_cfg[AB + 2*o + 1];
            nx[o]     = rst ? 1'b0 : sum_of(cur_cfg, o, v, ffm);
        end
        check(tag, out_data, exp_d);
        check("R8 enable bits", out_oe, exp_oe);
        @(posedge clk);
        ffm = nx;
        @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        for (int v = 0; v < 16; v++) run_vec(v[NI-1:0], tag);
    endtask

    function automatic logic [W-1:0] poison_all();
        logic [W-1:0] c = '0;
        for (int t = 0; t < NO * PT; t++) begin
            c = put(c, t, 0, 0);
            c = put(c, t, 0, 1);
        end
        return c;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [W-1:0] c;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ffm = '0;

        // R2 + R5: empty terms give 1; output 0 combinational and enabled, output 1 disabled.
        c = '0;
        c = ctl(c, 0, 1'b0, 1'b1);
        c = ctl(c, 1, 1'b0, 1'b0);
        load(c);
        sweep("R2 R5 empty term is one");

        // R3: both rails of one literal in every term give 0.
        c = ctl(poison_all(), 0, 1'b0, 1'b1);
        c = ctl(c, 1, 1'b0, 1'b1);
        load(c);
        sweep("R3 both rails give zero");

        // R1 + R4: out0 = in0 & ~in1, out1 = in2 | ~in3; remaining terms are zero.
        c = poison_all();
        for (int t = 0; t < NO * PT; t++) begin
            c[t*2*NL] = 1'b0;
            c[t*2*NL + 1] = 1'b0;
        end
        c = put(c, 0, 0, 0); c = put(c, 0, 1, 1);
        for (int p = 1; p < PT; p++) begin c = put(c, p, 0, 0); c = put(c, p, 0, 1); end
        c = put(c, 4, 2, 0);
        c = put(c, 5, 3, 1);
        for (int p = 6; p < 8; p++) begin c = put(c, p, 0, 0); c = put(c, p, 0, 1); end
        c = ctl(c, 0, 1'b0, 1'b1);
        c = ctl(c, 1, 1'b0, 1'b1);
        load(c);
        for (int v = 0; v < 16; v++) begin
            logic [NO-1:0] e;
            in_pins = v[NI-1:0];
            #1;
            e[0] = v[0] & ~v[1];
            e[1] = v[2] | ~v[3];
            check("R1 R4 literal rails and fixed groups", out_data, e);
            @(negedge clk);
        end

        // R6 + R7: out0 registered toggler (~fb0), out1 registered follower (fb0).
        c = poison_all();
        for (int t = 0; t < NO * PT; t++) begin
            c[t*2*NL] = 1'b0;
            c[t*2*NL + 1] = 1'b0;
        end
        c = put(c, 0, 4, 1);
        for (int p = 1; p < PT; p++) begin c = put(c, p, 0, 0); c = put(c, p, 0, 1); end
        c = put(c, 4, 4, 0);
        for (int p = 5; p < 8; p++) begin c = put(c, p, 0, 0); c = put(c, p, 0, 1); end
        c = ctl(c, 0, 1'b1, 1'b1);
        c = ctl(c, 1, 1'b1, 1'b1);
        load(c);
        rst = 1'b1;
        @(posedge clk); ffm = '0;
        @(negedge clk);
        rst = 1'b0;
        check("R9 flip-flops cleared", out_data, 2'b00);
        begin
            logic [NO-1:0] seq [4] = '{2'b01, 2'b10, 2'b01, 2'b10};
            for (int k = 0; k < 4; k++) begin
                @(posedge clk);
                @(negedge clk);
                check("R6 R7 toggle and follow", out_data, seq[k]);
            end
            ffm = 2'b10;
        end
        // R10: flip-flops hold while reloading the same image.
        load(c);
        check("R10 flip-flops hold during load", out_data, 2'b10);
        // R9: reset mid-run keeps configuration.
        rst = 1'b1;
        @(posedge clk); ffm = '0;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset clears, configuration kept", out_data, 2'b00);
        @(posedge clk);
        @(negedge clk);
        check("R9 toggling resumes after reset", out_data, 2'b01);
        ffm = 2'b01;
        sweep("R6 R7 model sequence");

        // Sparse pseudo-random configurations.
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < W; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                c[i] = lfsr[3] & lfsr[9];
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            c = ctl(c, 0, lfsr[5], 1'b1);
            c = ctl(c, 1, lfsr[11], lfsr[17]);
            load(c);
            sweep("R1 R4 R5 R6 R7 random image");
            sweep("R1 R4 R5 R6 R7 random image second pass");
        end

        summary();
    end
endmodule